// File: doc/BRIEF.md
# Multi-Range Window Comparator

This block compares the present values of four counters against a table of windows. Each counter has its own eight entries. An entry holds a lower limit, an upper limit and an output pattern. The limits are eight-digit packed BCD numbers, four bits per digit. On every clock cycle the block checks each counter value against all eight of that counter's entries. It then forms that counter's result word by ORing the patterns of every entry whose window contains the value.

The four result words are registered and driven out. A narrow slice of each word (bits 8 to 11) is also merged across the four counters by a bitwise OR onto four shared external output pins. The block raises no interrupt. Its effects appear only in the result words and on the external pins.

The table is loaded through a single-word write port. Each write selects a counter, an entry and a field.

Top module: `mrw_window_cmp`

## Requirements
- R1: A synchronous active-high reset clears every limit and pattern to zero and drives all result words and external outputs to zero. With a cleared table, every result is zero for any present value.
- R2: An entry contributes its pattern when lower limit <= present value <= upper limit. Both limits are inclusive. The comparison is on the BCD-encoded 32-bit magnitude, with the most significant digit in bits 31:28.
- R3: A result word is the bitwise OR of the patterns of all entries that contain the value. It is zero when no entry does.
- R4: An entry whose lower limit is greater than its upper limit never contributes, even when the value equals one of its limits.
- R5: Results are registered. A change of a present value shows in the result word after the next rising clock edge and not before it.
- R6: External output k (k = 0..3) is the OR over all four counters of bit 8+k of their result words.
- R7: A write with write enable high stores the write data in the field chosen by the field code: 0 = lower limit, 1 = upper limit, 2 = pattern (low 16 bits of the data). The field is in entry wr_idx_i (0..7) of counter wr_cnt_i (0..3). Field code 3 changes nothing. A write touches only the addressed field of the addressed entry of the addressed counter.
- R8: Present value c occupies bits 32c+31:32c of pv_i, and result word c occupies bits 16c+15:16c of result_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pv_i | input | 128 | Four packed-BCD present values, counter 0 in the low bits |
| wr_en_i | input | 1 | Table write enable |
| wr_cnt_i | input | 2 | Counter selected by a write |
| wr_idx_i | input | 3 | Entry selected by a write |
| wr_field_i | input | 2 | Field code: 0 lower, 1 upper, 2 pattern, 3 none |
| wr_data_i | input | 32 | Write data |
| result_o | output | 64 | Four registered 16-bit result words |
| ext_o | output | 4 | Merged external outputs |

## Verification
The hardest case to reach from the ports is a value lying in several windows at once while another window with swapped limits sits at the same point. A second hard case is a value at a limit where a BCD digit rolls over (099 against 100). Random tables over a narrow value span cannot be relied on to produce either case. The stimulus therefore first loads directed entries with overlapping, inverted and carry-edge limits and sweeps the value across each boundary. After that, random writes and values drawn from a small BCD span keep overlaps frequent. A reference table kept in the bench tracks every write.

// File: rtl/mrw_pkg.sv
package mrw_pkg;
    // Field selector codes of the table write port
    typedef enum logic [1:0] {
        FLD_LO   = 2'd0,
        FLD_HI   = 2'd1,
        FLD_PAT  = 2'd2,
        FLD_NONE = 2'd3
    } fld_e;
endpackage

// File: rtl/mrw_range_table.sv
module mrw_range_table #(
    parameter int NUM_CNT = 4,
    parameter int NUM_RNG = 8,
    parameter int VAL_W   = 32,
    parameter int PAT_W   = 16,
    localparam int CW = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1,
    localparam int IW = (NUM_RNG > 1) ? $clog2(NUM_RNG) : 1
) (
    input  logic                                             clk,
    input  logic                                             rst,
    input  logic                                             wr_en_i,
    input  logic [CW-1:0]                                    wr_cnt_i,
    input  logic [IW-1:0]                                    wr_idx_i,
    input  logic [1:0]                                       wr_field_i,
    input  logic [VAL_W-1:0]                                 wr_data_i,
    output logic [NUM_CNT-1:0][NUM_RNG-1:0][VAL_W-1:0]       lo_o,
    output logic [NUM_CNT-1:0][NUM_RNG-1:0][VAL_W-1:0]       hi_o,
    output logic [NUM_CNT-1:0][NUM_RNG-1:0][PAT_W-1:0]       pat_o
);
    import mrw_pkg::*;

    typedef struct packed {
        logic [NUM_CNT-1:0][NUM_RNG-1:0][VAL_W-1:0] lo;
        logic [NUM_CNT-1:0][NUM_RNG-1:0][VAL_W-1:0] hi;
        logic [NUM_CNT-1:0][NUM_RNG-1:0][PAT_W-1:0] pat;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en_i) begin
            case (fld_e'(wr_field_i))
                FLD_LO:  tbl_d.lo[wr_cnt_i][wr_idx_i]  = wr_data_i;
                FLD_HI:  tbl_d.hi[wr_cnt_i][wr_idx_i]  = wr_data_i;
                FLD_PAT: tbl_d.pat[wr_cnt_i][wr_idx_i] = wr_data_i[PAT_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) tbl_q <= '0;
        else     tbl_q <= tbl_d;
    end

    assign lo_o  = tbl_q.lo;
    assign hi_o  = tbl_q.hi;
    assign pat_o = tbl_q.pat;

    // R7
    none_write_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_field_i == 2'd3) |=> $stable(tbl_q));

    // R7
    lo_write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_field_i == 2'd0) |=>
            (tbl_q.lo[$past(wr_cnt_i)][$past(wr_idx_i)] == $past(wr_data_i)));
endmodule

// File: rtl/mrw_window_match.sv
module mrw_window_match #(
    parameter int NUM_RNG = 8,
    parameter int VAL_W   = 32,
    parameter int PAT_W   = 16
) (
    input  logic [VAL_W-1:0]                    pv_i,
    input  logic [NUM_RNG-1:0][VAL_W-1:0]       lo_i,
    input  logic [NUM_RNG-1:0][VAL_W-1:0]       hi_i,
    input  logic [NUM_RNG-1:0][PAT_W-1:0]       pat_i,
    output logic [NUM_RNG-1:0]                  hit_o,
    output logic [PAT_W-1:0]                    word_o
);
    // Packed BCD orders like plain unsigned binary, so a magnitude
    // compare of the raw vectors is a decimal compare.
    for (genvar r = 0; r < NUM_RNG; r++) begin : g_win
        logic above_lo, below_hi;
        assign above_lo = (pv_i >= lo_i[r]);
        assign below_hi = (pv_i <= hi_i[r]);
        assign hit_o[r] = above_lo && below_hi;
    end

    always_comb begin
        word_o = '0;
        for (int r = 0; r < NUM_RNG; r++) begin
            if (hit_o[r]) word_o = word_o | pat_i[r];
        end
    end
endmodule

// File: rtl/mrw_output_merge.sv
module mrw_output_merge #(
    parameter int NUM_CNT = 4,
    parameter int EXT_W   = 4
) (
    input  logic [NUM_CNT-1:0][EXT_W-1:0] tap_i,
    output logic [EXT_W-1:0]              ext_o
);
    for (genvar k = 0; k < EXT_W; k++) begin : g_pin
        logic [NUM_CNT-1:0] col;
        for (genvar c = 0; c < NUM_CNT; c++) begin : g_col
            assign col[c] = tap_i[c][k];
        end
        assign ext_o[k] = |col;
    end
endmodule

// File: rtl/mrw_window_cmp.sv
module mrw_window_cmp #(
    parameter int NUM_CNT = 4,
    parameter int NUM_RNG = 8,
    parameter int VAL_W   = 32,
    parameter int PAT_W   = 16,
    parameter int EXT_LSB = 8,
    parameter int EXT_W   = 4,
    localparam int CW = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1,
    localparam int IW = (NUM_RNG > 1) ? $clog2(NUM_RNG) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_CNT*VAL_W-1:0]   pv_i,
    input  logic                       wr_en_i,
    input  logic [CW-1:0]              wr_cnt_i,
    input  logic [IW-1:0]              wr_idx_i,
    input  logic [1:0]                 wr_field_i,
    input  logic [VAL_W-1:0]           wr_data_i,
    output logic [NUM_CNT*PAT_W-1:0]   result_o,
    output logic [EXT_W-1:0]           ext_o
);
    typedef struct packed {
        logic [NUM_CNT-1:0][PAT_W-1:0] res;
    } state_t;

    logic [NUM_CNT-1:0][NUM_RNG-1:0][VAL_W-1:0] lo_w, hi_w;
    logic [NUM_CNT-1:0][NUM_RNG-1:0][PAT_W-1:0] pat_w;
    logic [NUM_CNT-1:0][PAT_W-1:0]              word_w;
    logic [NUM_CNT-1:0][PAT_W-1:0]              pat_any;
    logic [NUM_CNT-1:0][EXT_W-1:0]              tap_w;
    state_t state_d, state_q;

    mrw_range_table #(
        .NUM_CNT(NUM_CNT), .NUM_RNG(NUM_RNG), .VAL_W(VAL_W), .PAT_W(PAT_W)
    ) u_table (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en_i),
        .wr_cnt_i  (wr_cnt_i),
        .wr_idx_i  (wr_idx_i),
        .wr_field_i(wr_field_i),
        .wr_data_i (wr_data_i),
        .lo_o      (lo_w),
        .hi_o      (hi_w),
        .pat_o     (pat_w)
    );

    for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
        logic [NUM_RNG-1:0] hit_w;
        mrw_window_match #(
            .NUM_RNG(NUM_RNG), .VAL_W(VAL_W), .PAT_W(PAT_W)
        ) u_match (
            .pv_i  (pv_i[c*VAL_W +: VAL_W]),
            .lo_i  (lo_w[c]),
            .hi_i  (hi_w[c]),
            .pat_i (pat_w[c]),
            .hit_o (hit_w),
            .word_o(word_w[c])
        );

        always_comb begin
            pat_any[c] = '0;
            for (int r = 0; r < NUM_RNG; r++) pat_any[c] = pat_any[c] | pat_w[c][r];
        end

        // R2
        result_within_patterns_chk: assert property (@(posedge clk) disable iff (rst)
            ((state_q.res[c] & ~$past(pat_any[c])) == '0));
    end

    always_comb begin
        state_d.res = word_w;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    always_comb begin
        for (int c = 0; c < NUM_CNT; c++) tap_w[c] = state_q.res[c][EXT_LSB +: EXT_W];
    end

    mrw_output_merge #(.NUM_CNT(NUM_CNT), .EXT_W(EXT_W)) u_merge (
        .tap_i(tap_w),
        .ext_o(ext_o)
    );

    assign result_o = state_q.res;

    // R1
    reset_clears_out_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (result_o == '0 && ext_o == '0));
endmodule

// File: tb/sim_mrw_window_cmp.sv
module sim_mrw_window_cmp;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [127:0] pv_i = '0;
    logic         wr_en_i = 1'b0;
    logic [1:0]   wr_cnt_i = '0;
    logic [2:0]   wr_idx_i = '0;
    logic [1:0]   wr_field_i = '0;
    logic [31:0]  wr_data_i = '0;
    logic [63:0]  result_o;
    logic [3:0]   ext_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] m_lo  [4][8];
    logic [31:0] m_hi  [4][8];
    logic [15:0] m_pat [4][8];
    logic [31:0] cur_pv [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    mrw_window_cmp u0 (
        .clk(clk), .rst(rst), .pv_i(pv_i), .wr_en_i(wr_en_i),
        .wr_cnt_i(wr_cnt_i), .wr_idx_i(wr_idx_i), .wr_field_i(wr_field_i),
        .wr_data_i(wr_data_i), .result_o(result_o), .ext_o(ext_o)
    );

    function automatic logic [31:0] to_bcd(int unsigned v);
        logic [31:0] b = '0;
        for (int d = 0; d < 8; d++) begin
            b[d*4 +: 4] = 4'(v % 10);
            v = v / 10;
        end
        return b;
    endfunction

    function automatic logic [15:0] exp_word(int c, logic [31:0] v);
        logic [15:0] w = '0;
        for (int r = 0; r < 8; r++)
            if (m_lo[c][r] <= v && v <= m_hi[c][r]) w = w | m_pat[c][r];
        return w;
    endfunction

    function automatic logic [3:0] exp_ext();
        logic [3:0] e = '0;
        for (int c = 0; c < 4; c++) e = e | exp_word(c, cur_pv[c])[11:8];
        return e;
    endfunction

    task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic check_all(string tag);
        for (int c = 0; c < 4; c++)
            check(tag, 64'(result_o[c*16 +: 16]), 64'(exp_word(c, cur_pv[c])));
        check({tag, " R6 ext"}, 64'(ext_o), 64'(exp_ext()));
    endtask

    task automatic wr(int c, int i, int f, logic [31:0] data);
        wr_en_i = 1'b1; wr_cnt_i = 2'(c); wr_idx_i = 3'(i);
        wr_field_i = 2'(f); wr_data_i = data;
        @(posedge clk); @(negedge clk);
        wr_en_i = 1'b0;
        case (f)
            0: m_lo[c][i] = data;
            1: m_hi[c][i] = data;
            2: m_pat[c][i] = data[15:0];
            default: ;
        endcase
    endtask

    task automatic set_pv(int c, logic [31:0] v);
        cur_pv[c] = v;
        pv_i[c*32 +: 32] = v;
    endtask

    task automatic step_check(string tag);
        @(posedge clk); @(negedge clk);
        check_all(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int c = 0; c < 4; c++) begin
            cur_pv[c] = '0;
            for (int r = 0; r < 8; r++) begin
                m_lo[c][r] = '0; m_hi[c][r] = '0; m_pat[c][r] = '0;
            end
        end
        // R1: outputs zero while reset is held, whatever the inputs
        pv_i = {32'h00000123, 32'h00000456, 32'h00000789, 32'h00000001};
        wr_en_i = 1'b1; wr_field_i = 2'd2; wr_data_i = 32'hFFFF;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R1 reset result", 64'(result_o), 64'h0);
        check("R1 reset ext", 64'(ext_o), 64'h0);
        wr_en_i = 1'b0;
        rst = 1'b0;
        for (int c = 0; c < 4; c++) set_pv(c, 32'h0);
        step_check("R1 cleared table at zero value");

        // R2 inclusive limits with BCD digit carry at the edges
        wr(0, 0, 0, to_bcd(100));
        wr(0, 0, 1, to_bcd(199));
        wr(0, 0, 2, 32'h0100);
        set_pv(0, to_bcd(100)); step_check("R2 lower limit");
        set_pv(0, to_bcd(199)); step_check("R2 upper limit");
        set_pv(0, to_bcd(99));  step_check("R2 below lower");
        set_pv(0, to_bcd(200)); step_check("R2 above upper");

        // R3 overlap ORs patterns
        wr(0, 1, 0, to_bcd(150));
        wr(0, 1, 1, to_bcd(300));
        wr(0, 1, 2, 32'h0A01);
        set_pv(0, to_bcd(160)); step_check("R3 overlap");
        check("R3 overlap value", 64'(result_o[15:0]), 64'h0B01);
        set_pv(0, to_bcd(1000)); step_check("R3 no match");

        // R4 inverted entry
        wr(0, 2, 0, to_bcd(500));
        wr(0, 2, 1, to_bcd(400));
        wr(0, 2, 2, 32'hF000);
        set_pv(0, to_bcd(450)); step_check("R4 inside swapped");
        set_pv(0, to_bcd(500)); step_check("R4 at swapped lower");
        set_pv(0, to_bcd(400)); step_check("R4 at swapped upper");

        // R7 field code 3 changes nothing
        set_pv(0, to_bcd(120)); step_check("R7 before none write");
        wr(0, 0, 3, 32'h0);
        @(negedge clk);
        check_all("R7 after none write");

        // R7/R8 counter isolation, R6 merge
        wr(1, 0, 0, 32'h0);
        wr(1, 0, 1, 32'h99999999);
        wr(1, 0, 2, 32'h0200);
        set_pv(1, 32'h99999999); step_check("R8 counter1 top value");
        check("R6 merged pins", 64'(ext_o), 64'h3);
        check("R7 counter0 untouched", 64'(result_o[15:0]), 64'h0100);

        // R5 one-cycle latency
        set_pv(0, to_bcd(250));
        #1;
        check("R5 before edge", 64'(result_o[15:0]), 64'h0100);
        @(posedge clk); @(negedge clk);
        check("R5 after edge", 64'(result_o[15:0]), 64'h0A01);

        // Random phase over a narrow BCD span
        for (int n = 0; n < 600; n++) begin
            if ($urandom_range(0, 2) == 0) begin
                int c = $urandom_range(0, 3);
                int i = $urandom_range(0, 7);
                int f = $urandom_range(0, 3);
                logic [31:0] d = (f == 2) ? 32'($urandom) : to_bcd($urandom_range(0, 600));
                wr(c, i, f, d);
            end else begin
                for (int c = 0; c < 4; c++) set_pv(c, to_bcd($urandom_range(0, 620)));
                step_check("R2 R3 R4 random");
            end
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule